// File: doc/BRIEF.md
# Programmable Down-Counting Timer Channel

This block is a single 16-bit timer channel that counts down once for every falling edge seen on a slow external count clock. It runs on a fast system clock and samples both the count clock and a gate input through a synchronizer. A host selects one of six operating modes with a program strobe, then writes a reload value with a load strobe. The chosen mode decides what starts counting (a register load or a rising gate edge), whether the gate level pauses counting, whether the channel reloads itself, and how the output waveform looks.

A load or a gate trigger does not change the count at once. It arms a pending start, and the next count-clock falling edge copies the reload value into the counter. Every later falling edge then steps the counter. Typical uses are a one-shot delay (modes 0, 1, 4 and 5), a periodic rate pulse (mode 2) and a square-wave generator (mode 3).

Top module: `tmr_channel`

## Requirements
- R1: After reset the channel is in mode 0. The count reads 0, the output is low and the error flag is low. A load of 2 followed by one count-clock falling edge gives count 2 with the output still low, as mode 0 requires.
- R2: The count changes only on a count-clock falling edge or on a program strobe. The first falling edge after a start copies the reload value into the count. Each later falling edge steps the count.
- R3: Mode 0 (mode code 0) drives the output low when the reload value is taken. It drives the output high when the count steps to 0 and keeps it high while the count wraps on to 65535. While the gate is low the count holds.
- R4: Mode 1 (code 1) ignores loads as a start. A rising gate edge starts the count and drives the output low until the count reaches 0. A second rising gate edge while counting restarts the count from the reload value. The gate level does not pause counting.
- R5: Mode 2 (code 2) reloads on the falling edge after the count reaches 1. The output is low only while the count equals 1. A reload value of 0 steps to 65535.
- R6: Mode 3 (code 3) steps the count by two. An odd reload value starts one lower. The channel reloads on the falling edge after the count reaches 2 and toggles the output at each reload, starting high. A reload value of 0 steps to 65534.
- R7: A load of value 1 in mode 2 or mode 3 sets the error flag and is otherwise ignored: the count continues undisturbed. A later legal load or a program strobe clears the flag.
- R8: Mode 4 (code 4) starts on a load. When the count reaches 0 it drives the output low for exactly one count-clock period. The output is high again at the next falling edge and the count keeps wrapping.
- R9: Mode 5 (code 5) ignores loads as a start. It starts on a rising gate edge and gives the same single one-period low pulse at 0 as mode 4.
- R10: In modes 0 and 4 a rising gate edge does not restart the count.
- R11: A program strobe clears the count and any pending start. It sets the output low for mode 0 and high for every other mode. Mode codes 6 and 7 act as modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tclk_in | input | 1 | Asynchronous count clock; counts on its falling edge |
| gate_in | input | 1 | Asynchronous gate: a trigger or a pause, depending on mode |
| prog_stb | input | 1 | One-cycle strobe that selects the mode from mode_code |
| mode_code | input | 3 | Mode number, sampled on prog_stb |
| load_stb | input | 1 | One-cycle strobe that writes load_val as the reload value |
| load_val | input | 16 | Reload value; 0 means a full-range period |
| count_o | output | 16 | Current count |
| out_o | output | 1 | Mode-shaped timer output |
| err_o | output | 1 | Set by an illegal load of 1 in modes 2 and 3 |

## Verification
A bad pending-start flag shows up at the first count-clock falling edge after a load or gate edge: the count either fails to take the reload value or takes it again in mid-count. A wrong mode register shows within one or two count periods, in the step size (one or two), in the output level right after the load, or in whether the gate edge restarts the count. A lost single-pulse arm flag shows up as a missing or extra low output pulse at count 0. A wrong step near the wrap boundary shows at once as a reload value of 0 giving anything other than 65535 or 65534 after the first step.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        M_TERM    = 3'd0,
        M_ONESHOT = 3'd1,
        M_RATE    = 3'd2,
        M_SQUARE  = 3'd3,
        M_SWSTB   = 3'd4,
        M_HWSTB   = 3'd5
    } tmr_mode_e;

    // codes 6 and 7 fold onto the rate and square modes
    function automatic tmr_mode_e decode_mode(input logic [2:0] code);
        case (code)
            3'd0:    return M_TERM;
            3'd1:    return M_ONESHOT;
            3'd2:    return M_RATE;
            3'd3:    return M_SQUARE;
            3'd4:    return M_SWSTB;
            3'd5:    return M_HWSTB;
            3'd6:    return M_RATE;
            default: return M_SQUARE;
        endcase
    endfunction

    function automatic logic gate_starts(input tmr_mode_e m);
        return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTB);
    endfunction

    function automatic logic load_starts(input tmr_mode_e m);
        return !((m == M_ONESHOT) || (m == M_HWSTB));
    endfunction

    function automatic logic gate_pauses(input tmr_mode_e m);
        return (m == M_TERM) || (m == M_RATE) || (m == M_SQUARE) || (m == M_SWSTB);
    endfunction

    function automatic logic is_periodic(input tmr_mode_e m);
        return (m == M_RATE) || (m == M_SQUARE);
    endfunction

    function automatic logic is_strobe(input tmr_mode_e m);
        return (m == M_SWSTB) || (m == M_HWSTB);
    endfunction

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } tmr_edges_t;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync
    import tmr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       raw,
    output tmr_edges_t edges
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], raw};
            prev_q <= sh_q[STAGES-1];
        end
    end

    always_comb begin
        edges.level = sh_q[STAGES-1];
        edges.rise  = sh_q[STAGES-1] & ~prev_q;
        edges.fall  = ~sh_q[STAGES-1] & prev_q;
    end

    // R2: a falling edge is a single-cycle event
    a_r2_fall_single: assert property (@(posedge clk) disable iff (rst)
        edges.fall |=> !edges.fall);

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         prog_stb,
    input  tmr_mode_e    prog_mode,
    input  logic         load_stb,
    input  logic [W-1:0] load_val,
    input  logic         gate_rise,
    input  logic         tick,
    output tmr_mode_e    mode_q,
    output logic [W-1:0] reload_q,
    output logic         err_q,
    output logic         pend_q
);
    logic illegal;
    logic start;

    always_comb begin
        illegal = load_stb && is_periodic(mode_q) && (load_val == W'(1));
        start   = (load_stb && !illegal && load_starts(mode_q)) ||
                  (gate_rise && gate_starts(mode_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= M_TERM;
            reload_q <= '0;
            err_q    <= 1'b0;
            pend_q   <= 1'b0;
        end else if (prog_stb) begin
            mode_q   <= prog_mode;
            reload_q <= '0;
            err_q    <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            if (load_stb) begin
                if (illegal) begin
                    err_q <= 1'b1;
                end else begin
                    reload_q <= load_val;
                    err_q    <= 1'b0;
                end
            end
            if (start)
                pend_q <= 1'b1;
            else if (tick)
                pend_q <= 1'b0;
        end
    end

    // R7: the flag rises only after a rejected load
    a_r7_err_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> $past(load_stb && load_val == W'(1) && is_periodic(mode_q)));

    // R7: a rejected load leaves the reload value alone
    a_r7_reload_kept: assert property (@(posedge clk) disable iff (rst)
        (illegal && !prog_stb) |=> $stable(reload_q));

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         prog_stb,
    input  tmr_mode_e    prog_mode,
    input  tmr_mode_e    mode,
    input  logic [W-1:0] reload,
    input  logic         pend,
    input  logic         tick,
    input  logic         gate_lvl,
    output logic [W-1:0] cnt_q,
    output logic         out_q
);
    logic         run_q;
    logic         armed_q;
    logic [W-1:0] eff_reload;
    logic [W-1:0] step_cnt;
    logic         step_out;
    logic         step_arm;
    logic         may_step;

    always_comb begin
        eff_reload = (mode == M_SQUARE) ? {reload[W-1:1], 1'b0} : reload;
        may_step   = run_q && (gate_lvl || !gate_pauses(mode));
        step_cnt   = cnt_q - W'(1);
        step_out   = out_q;
        step_arm   = armed_q;
        case (mode)
            M_TERM, M_ONESHOT: begin
                if (step_cnt == '0)
                    step_out = 1'b1;
            end
            M_RATE: begin
                if (cnt_q == W'(1))
                    step_cnt = reload;
                step_out = (step_cnt != W'(1));
            end
            M_SQUARE: begin
                if (cnt_q == W'(2)) begin
                    step_cnt = eff_reload;
                    step_out = ~out_q;
                end else begin
                    step_cnt = cnt_q - W'(2);
                end
            end
            default: begin
                if (armed_q && step_cnt == '0) begin
                    step_out = 1'b0;
                    step_arm = 1'b0;
                end else begin
                    step_out = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            out_q   <= 1'b0;
            run_q   <= 1'b0;
            armed_q <= 1'b0;
        end else if (prog_stb) begin
            cnt_q   <= '0;
            out_q   <= (prog_mode != M_TERM);
            run_q   <= 1'b0;
            armed_q <= 1'b0;
        end else if (tick) begin
            if (pend) begin
                cnt_q   <= eff_reload;
                run_q   <= 1'b1;
                out_q   <= !((mode == M_TERM) || (mode == M_ONESHOT));
                armed_q <= is_strobe(mode);
            end else if (may_step) begin
                cnt_q   <= step_cnt;
                out_q   <= step_out;
                armed_q <= step_arm;
            end
        end
    end

    // R2: the count only moves on a count-clock edge or a program strobe
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !prog_stb) |=> $stable(cnt_q));

    // R5: a low output in rate mode only at count one
    a_r5_low_at_one: assert property (@(posedge clk) disable iff (rst)
        (mode == M_RATE && !out_q) |-> (cnt_q == W'(1)));

    // R6: square mode only ever holds even counts
    a_r6_even: assert property (@(posedge clk) disable iff (rst)
        (mode == M_SQUARE) |-> !cnt_q[0]);

    // R8: strobe pulses sit at count zero
    a_r8_pulse_at_zero: assert property (@(posedge clk) disable iff (rst)
        (is_strobe(mode) && !out_q) |-> (cnt_q == '0));

    // R3: once high, mode 0 output stays high until a new start
    a_r3_out_hold: assert property (@(posedge clk) disable iff (rst)
        (mode == M_TERM && out_q && !(tick && pend) && !prog_stb) |=> out_q);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int W         = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tclk_in,
    input  logic         gate_in,
    input  logic         prog_stb,
    input  logic [2:0]   mode_code,
    input  logic         load_stb,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count_o,
    output logic         out_o,
    output logic         err_o
);
    localparam int N_IN = 2;
    localparam int IDX_CLK = 0;
    localparam int IDX_GATE = 1;

    logic [N_IN-1:0] raw_in;
    tmr_edges_t      edg [N_IN];
    tmr_mode_e       mode_q;
    tmr_mode_e       prog_mode;
    logic [W-1:0]    reload_q;
    logic            pend_q;

    assign raw_in    = {gate_in, tclk_in};
    assign prog_mode = decode_mode(mode_code);

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        tmr_sync #(.STAGES(SYNC_DEPTH)) u_sync (
            .clk   (clk),
            .rst   (rst),
            .raw   (raw_in[g]),
            .edges (edg[g])
        );
    end

    tmr_ctrl #(.W(W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .prog_stb  (prog_stb),
        .prog_mode (prog_mode),
        .load_stb  (load_stb),
        .load_val  (load_val),
        .gate_rise (edg[IDX_GATE].rise),
        .tick      (edg[IDX_CLK].fall),
        .mode_q    (mode_q),
        .reload_q  (reload_q),
        .err_q     (err_o),
        .pend_q    (pend_q)
    );

    tmr_core #(.W(W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .prog_stb  (prog_stb),
        .prog_mode (prog_mode),
        .mode      (mode_q),
        .reload    (reload_q),
        .pend      (pend_q),
        .tick      (edg[IDX_CLK].fall),
        .gate_lvl  (edg[IDX_GATE].level),
        .cnt_q     (count_o),
        .out_q     (out_o)
    );

endmodule

// File: tb/tmr_channel_tb_top.sv
module tmr_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tclk_in = 1'b0;
    logic        gate_in = 1'b0;
    logic        prog_stb = 1'b0;
    logic [2:0]  mode_code = 3'd0;
    logic        load_stb = 1'b0;
    logic [15:0] load_val = 16'd0;
    logic [15:0] count_o;
    logic        out_o;
    logic        err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    tmr_channel dut_i (
        .clk(clk), .rst(rst), .tclk_in(tclk_in), .gate_in(gate_in),
        .prog_stb(prog_stb), .mode_code(mode_code), .load_stb(load_stb),
        .load_val(load_val), .count_o(count_o), .out_o(out_o), .err_o(err_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tclk_in = 1'b1;
        repeat (4) @(negedge clk);
        tclk_in = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_gate(input logic v);
        @(negedge clk) gate_in = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic do_load(input int v);
        @(negedge clk);
        load_stb = 1'b1;
        load_val = 16'(v);
        @(negedge clk);
        load_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_prog(input int m);
        @(negedge clk);
        prog_stb  = 1'b1;
        mode_code = 3'(m);
        @(negedge clk);
        prog_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 count", count_o, 0);
        chk("R1 out", out_o, 0);
        chk("R1 err", err_o, 0);
        do_gate(1'b1);
        do_load(2);
        do_tick();
        chk("R1 mode0 count", count_o, 2);
        chk("R1 mode0 out low", out_o, 0);
    endtask

    task automatic t_mode0();
        do_prog(0);
        chk("R11 prog mode0 out", out_o, 0);
        do_load(5);
        chk("R2 no change before edge", count_o, 0);
        do_tick();
        chk("R2 load at edge", count_o, 5);
        chk("R3 out low", out_o, 0);
        for (int i = 0; i < 4; i++) do_tick();
        chk("R2 count 1", count_o, 1);
        chk("R3 out still low", out_o, 0);
        do_tick();
        chk("R3 count 0", count_o, 0);
        chk("R3 out high", out_o, 1);
        do_tick();
        chk("R3 wrap", count_o, 65535);
        chk("R3 out stays high", out_o, 1);
        do_gate(1'b0);
        do_tick();
        chk("R3 gate pause", count_o, 65535);
        do_gate(1'b1);
        do_tick();
        chk("R10 mode0 gate edge ignored", count_o, 65534);
    endtask

    task automatic t_mode1();
        do_prog(1);
        chk("R11 prog mode1 out", out_o, 1);
        do_load(3);
        do_tick();
        chk("R4 load not a start", count_o, 0);
        do_gate(1'b0);
        do_gate(1'b1);
        do_tick();
        chk("R4 trigger load", count_o, 3);
        chk("R4 out low", out_o, 0);
        do_tick();
        chk("R4 step", count_o, 2);
        do_gate(1'b0);
        do_tick();
        chk("R4 gate low no pause", count_o, 1);
        do_gate(1'b1);
        do_tick();
        chk("R4 retrigger", count_o, 3);
        for (int i = 0; i < 3; i++) do_tick();
        chk("R4 count 0", count_o, 0);
        chk("R4 out high", out_o, 1);
    endtask

    task automatic t_rate();
        do_prog(2);
        do_load(3);
        do_tick();
        chk("R5 load", count_o, 3);
        chk("R5 out high", out_o, 1);
        do_tick();
        do_tick();
        chk("R5 count 1", count_o, 1);
        chk("R5 out low at 1", out_o, 0);
        do_tick();
        chk("R5 reload", count_o, 3);
        chk("R5 out back high", out_o, 1);
        do_load(0);
        do_tick();
        chk("R5 zero load", count_o, 0);
        do_tick();
        chk("R5 zero wraps", count_o, 65535);
        do_load(1);
        chk("R7 err set", err_o, 1);
        do_tick();
        chk("R7 load ignored", count_o, 65534);
        do_load(4);
        chk("R7 err cleared by load", err_o, 0);
        do_tick();
        chk("R5 new load", count_o, 4);
    endtask

    task automatic t_square();
        do_prog(3);
        do_load(5);
        do_tick();
        chk("R6 odd minus one", count_o, 4);
        chk("R6 out starts high", out_o, 1);
        do_tick();
        chk("R6 step two", count_o, 2);
        do_tick();
        chk("R6 reload", count_o, 4);
        chk("R6 toggle low", out_o, 0);
        do_tick();
        do_tick();
        chk("R6 toggle high", out_o, 1);
        do_load(0);
        do_tick();
        do_tick();
        chk("R6 zero wraps", count_o, 65534);
        do_load(1);
        chk("R7 err square", err_o, 1);
        do_tick();
        chk("R7 square ignore", count_o, 65532);
        do_prog(3);
        chk("R7 err cleared by prog", err_o, 0);
        chk("R11 count cleared", count_o, 0);
    endtask

    task automatic t_swstb();
        do_prog(4);
        do_load(2);
        do_tick();
        chk("R8 load", count_o, 2);
        chk("R8 out high", out_o, 1);
        do_tick();
        chk("R8 out high at 1", out_o, 1);
        do_tick();
        chk("R8 count 0", count_o, 0);
        chk("R8 pulse low", out_o, 0);
        do_tick();
        chk("R8 wrap", count_o, 65535);
        chk("R8 pulse end", out_o, 1);
        do_gate(1'b0);
        do_gate(1'b1);
        do_tick();
        chk("R10 mode4 gate edge ignored", count_o, 65534);
    endtask

    task automatic t_hwstb();
        do_prog(5);
        do_load(2);
        do_tick();
        chk("R9 load not a start", count_o, 0);
        do_gate(1'b0);
        do_gate(1'b1);
        do_tick();
        chk("R9 trigger", count_o, 2);
        do_tick();
        do_tick();
        chk("R9 pulse low", out_o, 0);
        do_tick();
        chk("R9 pulse end", out_o, 1);
        chk("R9 wrap", count_o, 65535);
    endtask

    task automatic t_alias();
        do_prog(7);
        do_load(5);
        do_tick();
        chk("R11 code7 square", count_o, 4);
        do_prog(6);
        chk("R11 code6 out high", out_o, 1);
        do_load(3);
        do_tick();
        do_tick();
        do_tick();
        chk("R11 code6 rate low", out_o, 0);
        do_tick();
        chk("R11 code6 reload", count_o, 3);
        do_load(2);
        do_prog(0);
        chk("R11 prog clears count", count_o, 0);
        chk("R11 prog mode0 low", out_o, 0);
        do_tick();
        chk("R11 pending dropped", count_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mode0();
        t_mode1();
        t_rate();
        t_square();
        t_swstb();
        t_hwstb();
        t_alias();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule